// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the per-beat column addresses of a DDR2-style burst. A command carries a start column, a read/write flag and a valid strobe. The mode image held beside the block gives the burst length and the burst type. The block keeps both values for the length of the burst. It puts out one column address per clock, and it marks the final beat.

The block reorders only the three least significant column bits. All higher bits pass through from the start column unchanged. A command that arrives while a burst is running is either accepted or rejected, depending on the burst length, the type of the new command and the beat position. A command that arrives during the final beat always starts a new burst on the next beat, with no gap. An abort input stops the running burst at once.

Top module: `burst_colseq`

## Requirements
- R1: The length field `mr_image[2:0]` selects the burst length: 3'b010 gives 4 beats and 3'b011 gives 8 beats. `beat_last` is high only on the final beat. The cycle after that beat is idle unless a new burst is loaded.
- R2: In 4-beat mode, the low two column bits are `(start+n) mod 4` when `mr_image[3]`=0 (sequential) and `start XOR n` when `mr_image[3]`=1 (interleaved). Here n is the beat number. Bit 2 keeps its start value.
- R3: In 8-beat interleaved mode (`mr_image[3]`=1), the low three bits are `start XOR n` for n = 0..7.
- R4: In 8-beat sequential mode, the low two bits are `(start+n) mod 4`. Bit 2 keeps its start value for beats 0-3 and is inverted for beats 4-7.
- R5: Column bits above bit 2 equal those of the start column on every beat of the burst.
- R6: A command sampled at a rising edge while the block is idle puts beat 0 on the outputs after that edge. One beat follows per clock. `beat_wr` shows the command's write flag.
- R7: A command sampled during the final beat is accepted, whatever its type. Its beat 0 follows on the next beat slot with no idle beat.
- R8: A command sampled during a non-final beat of a 4-beat burst is rejected. `cmd_reject` is high for one cycle after that edge, and the running burst goes on unchanged.
- R9: During an 8-beat burst, a new command is accepted before the final beat only if it has the same read/write type as the running burst and the current beat number is odd. In that case the new burst's beat 0 comes next. Any other command in that window is rejected as in R8.
- R10: A length field other than 3'b010 or 3'b011 drives `cfg_err` high in the same cycle. While the field is reserved, a command starts no burst and is rejected.
- R11: `abort` sampled high ends the running burst, so `beat_valid` is low after that edge. A command sampled together with `abort` is neither accepted nor rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mr_image | input | 4 | Mode image: [2:0] length field, [3] type (1 = interleaved) |
| cmd_valid | input | 1 | Column command present |
| cmd_wr | input | 1 | Command is a write (0 = read) |
| cmd_col | input | COL_W | Start column of the command |
| abort | input | 1 | Stop the running burst |
| beat_valid | output | 1 | A beat is on the outputs |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_wr | output | 1 | Read/write type of the current burst |
| cmd_reject | output | 1 | Command sampled at the previous edge was refused |
| cfg_err | output | 1 | Length field holds a reserved encoding |

## Verification
The registered outputs change one rising edge after their cause: beat 0 and `cmd_reject` appear after the edge that samples the command, each later beat comes one edge after the one before it, and `beat_valid` goes low one edge after `abort`. `cfg_err` is the only output that follows its input within the same cycle. The bench changes inputs on the falling edge and reads the registered outputs 1 ns after each rising edge, so every check lands on the first cycle in which the new value is due. The bench reads `cfg_err` before the next rising edge. A full sweep over every mode and every low start value runs the bursts back to back, and every beat is compared with an address computed in the bench.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

  localparam int LOW_W = 3;

  typedef enum logic [2:0] {
    LEN_FOUR  = 3'b010,
    LEN_EIGHT = 3'b011
  } len_code_e;

  // Low column bits for beat n of a burst.
  function automatic logic [LOW_W-1:0] beat_low(
    input logic [LOW_W-1:0] start,
    input logic [LOW_W-1:0] n,
    input logic             eight,
    input logic             intlv
  );
    logic [1:0] pair;
    logic       hi;
    pair = intlv ? (start[1:0] ^ n[1:0]) : (start[1:0] + n[1:0]);
    if (!eight)
      hi = start[2];
    else
      hi = start[2] ^ n[2];
    return {hi, pair};
  endfunction

  function automatic logic [LOW_W-1:0] final_beat(input logic eight);
    return eight ? 3'd7 : 3'd3;
  endfunction

endpackage

// File: rtl/colseq_cfg_decode.sv
module colseq_cfg_decode
  import colseq_pkg::*;
#(
  parameter int MR_W = 4
) (
  input  logic [MR_W-1:0] mr_image,
  output logic            cfg_ok,
  output logic            eight,
  output logic            intlv
);
  localparam int TYPE_BIT = 3;

  logic [2:0] len_field;

  assign len_field = mr_image[2:0];
  assign cfg_ok    = (len_field == LEN_FOUR) || (len_field == LEN_EIGHT);
  assign eight     = (len_field == LEN_EIGHT);
  assign intlv     = mr_image[TYPE_BIT];

endmodule

// File: rtl/colseq_arbiter.sv
module colseq_arbiter
  import colseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_wr,
  input  logic             abort,
  input  logic             cfg_ok,
  input  logic             active,
  input  logic             last,
  input  logic [LOW_W-1:0] cnt,
  input  logic             cur_eight,
  input  logic             cur_wr,
  output logic             load,
  output logic             cmd_reject
);

  logic free_slot;
  logic cut_ok;
  logic refuse;

  // A slot is free when idle or on the final beat (seamless chaining).
  assign free_slot = !active || last;
  // A cut is allowed only in 8-beat mode, for the same command type, on an odd beat.
  assign cut_ok    = cur_eight && (cmd_wr == cur_wr) && cnt[0];
  assign load      = cmd_valid && !abort && cfg_ok && (free_slot || cut_ok);
  assign refuse    = cmd_valid && !abort && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_reject <= 1'b0;
    else        cmd_reject <= refuse;
  end

  AST_NO_EVEN_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active && !last) |-> (cnt[0] && cur_eight)) else $error("even or short cut"); // R9

endmodule

// File: rtl/colseq_beat_gen.sv
module colseq_beat_gen
  import colseq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             abort,
  input  logic [COL_W-1:0] new_col,
  input  logic             new_wr,
  input  logic             new_eight,
  input  logic             new_intlv,
  output logic             active,
  output logic [LOW_W-1:0] cnt,
  output logic             cur_eight,
  output logic             cur_wr,
  output logic [COL_W-1:0] beat_col,
  output logic             last
);
  localparam int UP_W = COL_W - LOW_W;

  logic [COL_W-1:0] start_q;
  logic             intlv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      cur_eight <= 1'b0;
      cur_wr    <= 1'b0;
      intlv_q   <= 1'b0;
      start_q   <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (load) begin
      active    <= 1'b1;
      cnt       <= '0;
      cur_eight <= new_eight;
      cur_wr    <= new_wr;
      intlv_q   <= new_intlv;
      start_q   <= new_col;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 3'd1;
    end
  end

  assign last = active && (cnt == final_beat(cur_eight));

  generate
    if (UP_W > 0) begin : g_upper
      assign beat_col[COL_W-1:LOW_W] = start_q[COL_W-1:LOW_W];
    end
  endgenerate
  assign beat_col[LOW_W-1:0] = beat_low(start_q[LOW_W-1:0], cnt, cur_eight, intlv_q);

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active) else $error("abort ignored"); // R11
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load && !abort) |=> !active) else $error("burst overran"); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !load && !abort) |=> (active && cnt == $past(cnt) + 3'd1)) else $error("beat skipped"); // R6
  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && !load && !abort) |=> $stable(beat_col[COL_W-1:LOW_W])) else $error("upper bits moved"); // R5

endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import colseq_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int MR_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MR_W-1:0]  mr_image,
  input  logic             cmd_valid,
  input  logic             cmd_wr,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             abort,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             beat_wr,
  output logic             cmd_reject,
  output logic             cfg_err
);

  logic             cfg_ok, dec_eight, dec_intlv;
  logic             load, active, last, cur_eight, cur_wr;
  logic [LOW_W-1:0] cnt;

  colseq_cfg_decode #(.MR_W(MR_W)) u_dec (
    .mr_image (mr_image),
    .cfg_ok   (cfg_ok),
    .eight    (dec_eight),
    .intlv    (dec_intlv)
  );

  colseq_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_wr     (cmd_wr),
    .abort      (abort),
    .cfg_ok     (cfg_ok),
    .active     (active),
    .last       (last),
    .cnt        (cnt),
    .cur_eight  (cur_eight),
    .cur_wr     (cur_wr),
    .load       (load),
    .cmd_reject (cmd_reject)
  );

  colseq_beat_gen #(.COL_W(COL_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .abort     (abort),
    .new_col   (cmd_col),
    .new_wr    (cmd_wr),
    .new_eight (dec_eight),
    .new_intlv (dec_intlv),
    .active    (active),
    .cnt       (cnt),
    .cur_eight (cur_eight),
    .cur_wr    (cur_wr),
    .beat_col  (beat_col),
    .last      (last)
  );

  assign beat_valid = active;
  assign beat_last  = last;
  assign beat_wr    = cur_wr;
  assign cfg_err    = !cfg_ok;

  AST_CFG_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !beat_valid) |=> !beat_valid) else $error("start on reserved length"); // R10
  AST_SHORT_NO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !cur_eight && !beat_last && cmd_valid && !abort) |=> cmd_reject) else $error("4-beat burst cut"); // R8
  AST_LAST_SEAMLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && cmd_valid && !abort && !cfg_err) |=> (beat_valid && !cmd_reject)) else $error("gap after last"); // R7

endmodule

// File: tb/sim_burst_colseq.sv
module sim_burst_colseq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       mr_image = 4'b0010;
  logic             cmd_valid = 1'b0;
  logic             cmd_wr = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic             abort = 1'b0;
  logic             beat_valid, beat_last, beat_wr, cmd_reject, cfg_err;
  logic [COL_W-1:0] beat_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_colseq #(.COL_W(COL_W), .MR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .mr_image(mr_image), .cmd_valid(cmd_valid),
    .cmd_wr(cmd_wr), .cmd_col(cmd_col), .abort(abort), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .beat_wr(beat_wr),
    .cmd_reject(cmd_reject), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Expected full column, derived independently from the ordering rules.
  function automatic int exp_col(input int start, input int n, input bit eight, input bit intl);
    int lo, up, nib;
    lo = start % 8;
    up = start - lo;
    if (!eight) begin
      if (intl) return up + (lo & 4) + ((lo ^ n) & 3);
      return up + (lo & 4) + ((lo + n) % 4);
    end
    if (intl) return up + (lo ^ n);
    nib = (n < 4) ? (lo / 4) : (1 - lo / 4);
    return up + nib * 4 + ((lo + n) % 4);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int col, ec, blen;
    bit eight, intl;
    repeat (3) @(negedge clk);
    chk(beat_valid == 1'b0 && cmd_reject == 1'b0, "R6 reset idle", beat_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: four modes x eight low start values, all bursts back to back (R2 R3 R4 R5 R6 R7).
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 8; s++) begin
        eight = m[1];
        intl  = m[0];
        blen  = eight ? 8 : 4;
        col   = ((m * 8 + s) * 37 % 128) * 8 + s;
        mr_image  = {intl, 2'b01, eight};
        cmd_valid = 1'b1;
        cmd_wr    = s[0];
        cmd_col   = col[COL_W-1:0];
        for (int b = 0; b < blen; b++) begin
          tick();
          ec = exp_col(col, b, eight, intl);
          // R2 R3 R4 R5: ordering and pass-through of upper bits
          chk(beat_valid && int'(beat_col) == ec,
              eight ? (intl ? "R3 interleaved order" : "R4 nibble order") : "R2 short order",
              int'(beat_col), ec);
          chk(beat_last == (b == blen - 1), "R1 last flag", beat_last, b == blen - 1);
          chk(beat_wr == s[0] && !cmd_reject, "R6 R7 type and acceptance", beat_wr, s[0]);
          @(negedge clk);
          cmd_valid = 1'b0;
        end
      end
    end
    tick();
    chk(beat_valid == 1'b0, "R1 idle after final beat", beat_valid, 0);

    // R9: 8-beat read cut by reads and writes.
    @(negedge clk);
    mr_image = 4'b0011; cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 10'd0;
    tick();
    chk(int'(beat_col) == 0, "R6 start", int'(beat_col), 0);
    @(negedge clk);
    cmd_col = 10'd5;
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 1, "R9 even beat refused", int'(beat_col), 1);
    @(negedge clk);
    tick();
    chk(cmd_reject == 1'b0 && int'(beat_col) == 5, "R9 odd beat cut", int'(beat_col), 5);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_col = 10'd2;
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 6, "R9 write into read refused", int'(beat_col), 6);
    @(negedge clk);
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 7 && beat_wr == 1'b0, "R9 odd write still refused",
        int'(beat_col), 7);
    @(negedge clk);
    cmd_valid = 1'b0; abort = 1'b1;
    tick();
    chk(beat_valid == 1'b0, "R11 abort stops burst", beat_valid, 0);
    @(negedge clk);
    abort = 1'b0;

    // R8: 4-beat burst cannot be cut, even on an odd beat; final beat chains (R7).
    mr_image = 4'b0010; cmd_valid = 1'b1; cmd_wr = 1'b0; cmd_col = 10'd1;
    tick();
    @(negedge clk);
    cmd_col = 10'd3;
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 2, "R8 refused at beat 0", int'(beat_col), 2);
    @(negedge clk);
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 3, "R8 refused at beat 1", int'(beat_col), 3);
    @(negedge clk);
    tick();
    chk(cmd_reject == 1'b1 && int'(beat_col) == 0 && beat_last, "R8 refused at beat 2", int'(beat_col), 0);
    @(negedge clk);
    tick();
    chk(cmd_reject == 1'b0 && int'(beat_col) == 3 && beat_valid, "R7 chained after last", int'(beat_col), 3);

    // R11: abort wins over a simultaneous command.
    @(negedge clk);
    abort = 1'b1; cmd_col = 10'd6;
    tick();
    chk(beat_valid == 1'b0 && cmd_reject == 1'b0, "R11 abort over command", beat_valid, 0);
    @(negedge clk);
    abort = 1'b0; cmd_valid = 1'b0;

    // R10: reserved length encodings.
    for (int e = 0; e < 8; e++) begin
      if (e == 2 || e == 3) continue;
      @(negedge clk);
      mr_image = {1'b0, 3'(e)};
      cmd_valid = 1'b1;
      #1;
      chk(cfg_err == 1'b1, "R10 cfg_err raised", cfg_err, 1);
      tick();
      chk(beat_valid == 1'b0 && cmd_reject == 1'b1, "R10 no start, refused", beat_valid, 0);
    end
    @(negedge clk);
    cmd_valid = 1'b0; mr_image = 4'b1011;
    #1;
    chk(cfg_err == 1'b0, "R10 cfg_err clear on legal length", cfg_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule